// File: doc/BRIEF.md
# Configurable LUT Cluster Tile

This block models one logic cluster of a programmable fabric. It holds N logic elements. Each element has a K-input lookup table whose output feeds a D flip-flop, and a 2-to-1 output select that passes either the registered or the raw table value. Every table input is fed by a local crossbar. The crossbar can pick any of the I cluster inputs or any element output, so logic can be chained inside the cluster. Each element output drives one cluster output.

All programming enters serially. While `cfg_en` is high, one bit per clock is shifted into a staging chain, and the datapath keeps running on the configuration it already holds. On the first clock edge that samples `cfg_en` low after a high period, the whole staged image is copied into the working configuration in one step. A synchronous reset clears the element flip-flops only. The configuration survives reset.

Top module: `lut_cluster`

## Requirements
- R1: Serial load order. While `cfg_en` is high, `cfg_in` is shifted in one bit per clock, TOT = N·(2^K + 1 + K·S) bits in all, where S = ceil(log2(I+N)). Elements are sent in order from element 0 upwards. For each element the stream carries:
  - the 2^K table bits, bit 0 first;
  - the output-select bit;
  - the K select fields, input 0 first, each field least significant bit first.
  The staged image becomes active at the first edge that samples `cfg_en` low after a high period.
- R2: While `cfg_en` is high, the active configuration, and so the cluster's logic function, does not change.
- R3: An element's table output is table bit number v, where bit k of v is the value on table input k.
- R4: A select value c below I feeds `cl_in[c]` to the table input. A value c with I ≤ c < I+N feeds the output of element c−I.
- R5: A select value of I+N or above feeds a constant 0 to the table input.
- R6: The output-select bit chooses the element output. When it is 1, the output is the table value of the same cycle. When it is 0, the output is the flip-flop, which holds the table value sampled at the previous rising clock edge.
- R7: A clock edge that samples `rst` high clears every element flip-flop to 0. Reset does not alter the staged or the active configuration.
- R8: Combinational element outputs routed through the crossbar reach dependent elements within the same cycle. Registered outputs fed back form sequential loops.
- R9: Element e drives `cl_out[e]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock for all flip-flops and the configuration chain |
| rst | input | 1 | Synchronous active-high reset of the element flip-flops |
| cfg_en | input | 1 | Shift enable for the configuration chain; its falling edge commits the image |
| cfg_in | input | 1 | Serial configuration data |
| cl_in | input | I | Cluster inputs offered to the crossbar |
| cl_out | output | N | Element outputs, one per element |

## Verification
Two functions can act in the same cycle: a configuration reload shifting in, and the datapath computing and registering on the configuration it already holds. The bench provokes this by streaming a second image while random cluster inputs keep changing. It checks every cycle that the outputs still follow the first image. From the cycle after the commit edge, the outputs must follow the second image. A reset pulse is also issued in the middle of a run and while the first image is staged. This shows that flip-flops clear while table and select settings persist.

// File: rtl/lut_cluster_pkg.sv
package lut_cluster_pkg;

    typedef enum logic {
        OUT_REG  = 1'b0,
        OUT_COMB = 1'b1
    } out_mode_e;

    typedef struct packed {
        logic comb;
        logic regd;
    } elem_val_t;

    function automatic int sel_width(input int n_cand);
        int w;
        w = $clog2(n_cand);
        return (w < 1) ? 1 : w;
    endfunction

    function automatic int elem_cfg_bits(input int k, input int selw);
        return (1 << k) + 1 + k * selw;
    endfunction

endpackage

// File: rtl/cluster_cfg_store.sv
module cluster_cfg_store #(
    parameter int TOT = 8
) (
    input  logic           clk,
    input  logic           cfg_en,
    input  logic           cfg_in,
    output logic [TOT-1:0] shadow,
    output logic [TOT-1:0] active,
    output logic           en_q
);

    generate
        if (TOT > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (cfg_en) shadow <= {cfg_in, shadow[TOT-1:1]};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (cfg_en) shadow <= cfg_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        en_q <= cfg_en;
        if (!cfg_en && en_q) active <= shadow;
    end

endmodule

// File: rtl/cluster_xbar_lane.sv
module cluster_xbar_lane #(
    parameter int CAND = 8,
    parameter int K    = 4,
    parameter int SELW = 3
) (
    input  logic [CAND-1:0]   cand,
    input  logic [K*SELW-1:0] sels,
    output logic [K-1:0]      lane_out
);

    for (genvar k = 0; k < K; k++) begin : g_lane
        logic [SELW-1:0] sel;
        assign sel = sels[k*SELW +: SELW];
        always_comb begin
            lane_out[k] = 1'b0;
            for (int c = 0; c < CAND; c++) begin
                if (sel == SELW'(c)) lane_out[k] = cand[c];
            end
        end
    end

endmodule

// File: rtl/cluster_ble.sv
module cluster_ble
    import lut_cluster_pkg::*;
#(
    parameter int K = 4,
    localparam int LUTB = 1 << K
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LUTB-1:0] lut_bits,
    input  out_mode_e       mode,
    input  logic [K-1:0]    idx,
    output elem_val_t       val,
    output logic            o
);

    logic lut_o;
    logic ff_q;

    assign lut_o = lut_bits[idx];

    always_ff @(posedge clk) begin
        if (rst) ff_q <= 1'b0;
        else     ff_q <= lut_o;
    end

    assign val.comb = lut_o;
    assign val.regd = ff_q;
    assign o = (mode == OUT_COMB) ? lut_o : ff_q;

endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
    import lut_cluster_pkg::*;
#(
    parameter int N = 4,
    parameter int K = 4,
    parameter int I = K * (N + 1) / 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_en,
    input  logic         cfg_in,
    input  logic [I-1:0] cl_in,
    output logic [N-1:0] cl_out
);

    localparam int CAND = I + N;
    localparam int SELW = sel_width(CAND);
    localparam int LUTB = 1 << K;
    localparam int PER  = elem_cfg_bits(K, SELW);
    localparam int TOT  = N * PER;

    logic [TOT-1:0]  cfg_shadow;
    logic [TOT-1:0]  cfg_act;
    logic            cfg_en_q;
    logic [N-1:0]    elem_out;
    logic [N-1:0]    lut_v;
    logic [N-1:0]    ff_v;
    logic [CAND-1:0] cand;

    cluster_cfg_store #(.TOT(TOT)) u_cfg (
        .clk    (clk),
        .cfg_en (cfg_en),
        .cfg_in (cfg_in),
        .shadow (cfg_shadow),
        .active (cfg_act),
        .en_q   (cfg_en_q)
    );

    assign cand = {elem_out, cl_in};

    for (genvar e = 0; e < N; e++) begin : g_elem
        localparam int BASE = e * PER;
        logic [LUTB-1:0]   lut_bits;
        out_mode_e         mode;
        logic [K*SELW-1:0] sels;
        logic [K-1:0]      idx;
        elem_val_t         val;

        assign lut_bits = cfg_act[BASE +: LUTB];
        assign mode     = out_mode_e'(cfg_act[BASE + LUTB]);
        assign sels     = cfg_act[BASE + LUTB + 1 +: K*SELW];

        cluster_xbar_lane #(.CAND(CAND), .K(K), .SELW(SELW)) u_xbar (
            .cand     (cand),
            .sels     (sels),
            .lane_out (idx)
        );

        cluster_ble #(.K(K)) u_ble (
            .clk      (clk),
            .rst      (rst),
            .lut_bits (lut_bits),
            .mode     (mode),
            .idx      (idx),
            .val      (val),
            .o        (elem_out[e])
        );

        assign lut_v[e] = val.comb;
        assign ff_v[e]  = val.regd;
    end

    assign cl_out = elem_out;

endmodule

// File: rtl/lut_cluster_chk.sv
module lut_cluster_chk #(
    parameter int N   = 4,
    parameter int TOT = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_en,
    input logic           cfg_in,
    input logic           en_q,
    input logic [TOT-1:0] shadow,
    input logic [TOT-1:0] act,
    input logic [N-1:0]   lut_v,
    input logic [N-1:0]   ff_v
);

    // R1
    shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> shadow[TOT-1] == $past(cfg_in));

    // R1
    commit_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && en_q) |=> act == $past(shadow));

    // R2
    hold_during_shift_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> $stable(act));

    // R6
    ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ff_v == $past(lut_v));

    // R7
    ff_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ff_v == '0);

endmodule

bind lut_cluster lut_cluster_chk #(.N(N), .TOT(TOT)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cfg_en (cfg_en),
    .cfg_in (cfg_in),
    .en_q   (cfg_en_q),
    .shadow (cfg_shadow),
    .act    (cfg_act),
    .lut_v  (lut_v),
    .ff_v   (ff_v)
);

// File: tb/sim_lut_cluster.sv
`timescale 1ns/1ps
module sim_lut_cluster;

    localparam int N    = 4;
    localparam int K    = 4;
    localparam int I    = 10;
    localparam int CAND = I + N;
    localparam int SELW = 4;
    localparam int LUTB = 16;
    localparam int PER  = LUTB + 1 + K * SELW;
    localparam int TOT  = N * PER;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_en = 1'b0;
    logic         cfg_in = 1'b0;
    logic [I-1:0] cl_in = '0;
    logic [N-1:0] cl_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R7";

    logic [TOT-1:0] m_sh = '0;
    logic [TOT-1:0] m_act = '0;
    logic [N-1:0]   m_ff = '0;
    bit             m_enq = 1'b0;
    bit             valid = 1'b0;

    lut_cluster #(.N(N), .K(K), .I(I)) u0 (
        .clk    (clk),
        .rst    (rst),
        .cfg_en (cfg_en),
        .cfg_in (cfg_in),
        .cl_in  (cl_in),
        .cl_out (cl_out)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer than 20000)", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Behavioural model: relaxation over the elements until settled (loop-free configs only)
    function automatic void m_eval(input logic [I-1:0] x, output logic [N-1:0] o,
                                   output logic [N-1:0] lv);
        o  = '0;
        lv = '0;
        for (int pass = 0; pass <= N; pass++) begin
            for (int e = 0; e < N; e++) begin
                int base;
                int idx;
                base = e * PER;
                idx = 0;
                for (int k = 0; k < K; k++) begin
                    int sel;
                    logic v;
                    sel = 0;
                    for (int b = 0; b < SELW; b++)
                        if (m_act[base + LUTB + 1 + k*SELW + b]) sel += (1 << b);
                    if (sel < I)         v = x[sel];
                    else if (sel < CAND) v = o[sel - I];
                    else                 v = 1'b0;
                    if (v) idx += (1 << k);
                end
                lv[e] = m_act[base + idx];
                o[e]  = m_act[base + LUTB] ? lv[e] : m_ff[e];
            end
        end
    endfunction

    task automatic cyc(input bit nrst, input bit nen, input bit nin, input logic [I-1:0] nx);
        logic [N-1:0] eo;
        logic [N-1:0] lv;
        @(negedge clk);
        if (valid) begin
            m_eval(cl_in, eo, lv);
            checks++;
            if (cl_out !== eo) begin
                fails++;
                $display("FAIL %s: cl_out actual %b expected %b (cycle %0d)", cur_req, cl_out, eo, cycles);
            end
        end
        rst = nrst;
        cfg_en = nen;
        cfg_in = nin;
        cl_in = nx;
        m_eval(nx, eo, lv);
        m_ff = nrst ? '0 : lv;
        if (!nen && m_enq) begin
            m_act = m_sh;
            valid = 1'b1;
        end
        if (nen) m_sh = {nin, m_sh[TOT-1:1]};
        m_enq = nen;
    endtask

    function automatic void put(inout logic [TOT-1:0] c, input int e, input logic [15:0] lut,
                                input bit mode, input int s0, input int s1, input int s2,
                                input int s3);
        int base;
        int s[4];
        base = e * PER;
        s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
        for (int b = 0; b < LUTB; b++) c[base + b] = lut[b];
        c[base + LUTB] = mode;
        for (int k = 0; k < K; k++)
            for (int b = 0; b < SELW; b++)
                c[base + LUTB + 1 + k*SELW + b] = s[k][b];
    endfunction

    task automatic load(input logic [TOT-1:0] c, input bit rv);
        for (int i = 0; i < TOT; i++) cyc(rv, 1'b1, c[i], I'($urandom));
        cyc(rv, 1'b0, 1'b0, I'($urandom));
    endtask

    task automatic run(input int n, input bit rv);
        for (int i = 0; i < n; i++) cyc(rv, 1'b0, 1'b0, I'($urandom));
    endtask

    logic [TOT-1:0] cfg_a;
    logic [TOT-1:0] cfg_b;

    initial begin
        cfg_a = '0;
        // e0 comb XOR of cl_in[0..3] (R3, R4)
        put(cfg_a, 0, 16'h6996, 1'b1, 0, 1, 2, 3);
        // e1 registered AND of cl_in[4..7] (R6)
        put(cfg_a, 1, 16'h8000, 1'b0, 4, 5, 6, 7);
        // e2 comb copy of e0 via select 10, others 15 -> 0 (R5, R8)
        put(cfg_a, 2, 16'hAAAA, 1'b1, 10, 15, 15, 15);
        // e3 registered OR of cl_in8, cl_in9, e1, const 0 via select 14 (R5, R8)
        put(cfg_a, 3, 16'hFFFE, 1'b0, 8, 9, 11, 14);

        cfg_b = '0;
        // e0 registered NOR-style: 1 only when e3 low -> toggles through e3 (R8)
        put(cfg_b, 0, 16'h0001, 1'b0, 13, 15, 15, 15);
        put(cfg_b, 1, 16'h35C9, 1'b1, 9, 3, 5, 12);
        put(cfg_b, 2, 16'h0F0F, 1'b0, 0, 1, 2, 3);
        put(cfg_b, 3, 16'hAAAA, 1'b1, 10, 9, 9, 9);

        // Reset state with image A staged under reset (R1, R7)
        cur_req = "R7";
        run(3, 1'b1);
        load(cfg_a, 1'b1);
        run(3, 1'b1);

        // Main function, random inputs (R3 R4 R5 R6 R8 R9)
        cur_req = "R3/R4/R5/R6/R8/R9";
        run(80, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, '1);
        cyc(1'b0, 1'b0, 1'b0, '1);
        cyc(1'b0, 1'b0, 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b0, I'(10'h0F0));

        // Mid-run reset keeps configuration (R7)
        cur_req = "R7";
        run(3, 1'b1);
        run(20, 1'b0);

        // Reload while running: old image stays in force during shifting (R2)
        cur_req = "R2";
        for (int i = 0; i < TOT; i++) cyc(1'b0, 1'b1, cfg_b[i], I'($urandom));
        cur_req = "R1";
        cyc(1'b0, 1'b0, 1'b0, I'($urandom));
        cur_req = "R1/R3/R6/R8";
        run(80, 1'b0);
        cur_req = "R7";
        run(2, 1'b1);
        run(10, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule